// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters on one serial line in the non-return-to-zero asynchronous format. The host writes a byte into a one-entry holding register, plus a ninth bit if it wants one. The character then moves into a shift register and goes out as a start bit, the data bits with the least significant bit first, and a stop bit. While one character is on the line, the host may already write the next one. That character waits in the holding register and passes to the shift register in the same cycle that the previous stop bit ends, so consecutive frames follow each other with no idle gap.

An internal divider makes the bit clock from a divisor value. The divisor is either 16 bits wide or only its low 8 bits, and one bit period lasts either 16 or 64 divider ticks. The host sees three things:
- A holding-register-empty flag, whose drop after a write is visible only from the second cycle.
- An interrupt line, which is that flag gated by an enable.
- A shift-register-empty status, which has no interrupt.

The whole transmitter runs only while the port enable and the transmit enable are high and the synchronous-mode input is low.

Top module: `uart_dbuf_tx`

## Requirements
- R1: Each frame on `serial_out` is one start bit (0), then the data bits with bit 0 first, then one stop bit (1). Whenever no frame is in progress the line is 1.
- R2: With `nine_bit_mode`=1, the value of `wr_bit9` captured with the write goes out as a ninth data bit after data bit 7. With `nine_bit_mode`=0, the stop bit directly follows data bit 7 and `wr_bit9` is not sent.
- R3: One bit lasts M×(D+1) clock cycles.
  - M is 16 when `hi_speed`=1 and 64 when `hi_speed`=0.
  - D is `div_value` when `div_wide`=1, and only `div_value[7:0]` when `div_wide`=0 (the upper byte is ignored).
- R4: If the holding register holds a character when a stop bit ends, that character's start bit begins in the very next cycle. A character written while a frame is in progress waits, and the empty flag stays 0 until that handoff.
- R5: When a write is accepted in cycle c with the line idle, `serial_out` drops to 0 in cycle c+2.
- R6: After a write in cycle c:
  - `buf_empty` still reads 1 in cycle c+1.
  - It reads 0 in cycle c+2.
  - It returns to 1 in the cycle after the character has moved to the shift register.
- R7: While the transmitter is not enabled, `buf_empty` is 0. It reads 1 in the cycle after the enable condition becomes true.
- R8: `irq` equals `buf_empty` AND `irq_en`.
- R9: `shift_empty` is 1 while no frame is on the line. It is 0 from the first cycle of the start bit through the last cycle of the stop bit.
- R10: A write strobe is ignored unless `port_en`=1, `tx_en`=1 and `sync_mode`=0.
- R11: When the enable condition drops in the middle of a frame:
  - In the next cycle the line is 1 and `shift_empty` is 1.
  - The frame is not resumed.
  - The holding register is emptied.
- R12: After reset, with the transmitter disabled, `serial_out`=1, `shift_empty`=1, `buf_empty`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable; its rise forces the empty flag set |
| sync_mode | input | 1 | Synchronous mode select; must be 0 for this transmitter to run |
| nine_bit_mode | input | 1 | 1 selects 9 data bits per frame |
| hi_speed | input | 1 | 1: 16 ticks per bit, 0: 64 ticks per bit |
| div_wide | input | 1 | 1: full divisor, 0: low 8 divisor bits only |
| div_value | input | DIV_W | Baud divisor D (tick every D+1 cycles) |
| irq_en | input | 1 | Interrupt enable |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to send |
| wr_bit9 | input | 1 | Ninth data bit, captured with the write |
| serial_out | output | 1 | Serial line |
| buf_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Interrupt request |
| shift_empty | output | 1 | Shift register empty status |

## Verification
The bench builds the block with its defaults: 8-bit characters, a 16-bit divisor and an 8-bit narrow divisor. With these, small divisor values give bit periods of 16, 32, 48 and 64 cycles. Short runs therefore cover both oversampling ratios, a divisor whose upper byte must be masked in 8-bit mode, and full 9-bit frames. Checking the exact cycle at each bit boundary then confirms the divisor arithmetic as well as the back-to-back handoff.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int OVS_HI = 16;
  localparam int OVS_LO = 64;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_t;

endpackage

// File: rtl/txb_baud_gen.sv
module txb_baud_gen #(
  parameter int DIV_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             div_wide,
  input  logic [DIV_W-1:0] div_value,
  output logic             tick
);

  logic [DIV_W-1:0] reload;
  logic [DIV_W-1:0] cnt;

  generate
    if (DIV_W > NARROW_W) begin : g_mask
      always_comb reload = div_wide ? div_value
                                    : {{(DIV_W-NARROW_W){1'b0}}, div_value[NARROW_W-1:0]};
    end else begin : g_nomask
      always_comb reload = div_value;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt <= reload;
    end else if (cnt == '0) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && (cnt == '0);

  // R3: a nonzero divisor leaves at least one quiet cycle between ticks
  p_tick_space_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !restart && reload != '0) |=> !tick);

endmodule

// File: rtl/txb_hold_reg.sv
module txb_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic            wr_bit9,
  input  logic            take,
  input  logic            irq_en,
  output logic            hold_full,
  output logic [DATA_W:0] hold_word,
  output logic            buf_empty,
  output logic            irq
);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hold_full <= 1'b0;
    end else if (wr) begin
      hold_full <= 1'b1;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word <= '0;
    end else if (run && wr) begin
      hold_word <= {wr_bit9, wr_data};
    end
  end

  // flag trails the occupancy bit by one register stage
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      buf_empty <= 1'b0;
    end else begin
      buf_empty <= !hold_full;
    end
  end

  assign irq = buf_empty && irq_en;

  // R6: two cycles after an accepted write the flag reads low
  p_flag_drop_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(run && wr) && run) |=> !buf_empty);

  // R7: enabling forces the flag set
  p_flag_forced_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |=> buf_empty);

  // R7: disabled means flag low
  p_flag_off_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> !buf_empty);

endmodule

// File: rtl/txb_shift_eng.sv
module txb_shift_eng
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tick,
  input  logic            hi_speed,
  input  logic            nine_mode,
  input  logic            hold_full,
  input  logic [DATA_W:0] hold_word,
  output logic            take,
  output logic            line_o,
  output logic            shift_empty_o
);

  localparam int SUB_W  = $clog2(OVS_LO);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int WORD_W = DATA_W + 1;

  tx_state_t          state;
  logic [SUB_W-1:0]   sub_cnt;
  logic [SUB_W-1:0]   sub_last;
  logic [CNT_W-1:0]   bit_cnt;
  logic [CNT_W-1:0]   last_idx;
  logic [WORD_W-1:0]  shreg;
  logic               hs_r;
  logic               nine_r;
  logic               bit_end;

  always_comb begin
    sub_last = hs_r ? SUB_W'(OVS_HI - 1) : SUB_W'(OVS_LO - 1);
    last_idx = nine_r ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
    bit_end  = (state != TX_IDLE) && tick && (sub_cnt == sub_last);
    take     = run && hold_full &&
               ((state == TX_IDLE) || (state == TX_STOP && bit_end));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      state         <= TX_IDLE;
      line_o        <= 1'b1;
      shift_empty_o <= 1'b1;
      sub_cnt       <= '0;
      bit_cnt       <= '0;
      shreg         <= '0;
      hs_r          <= 1'b1;
      nine_r        <= 1'b0;
    end else if (take) begin
      state         <= TX_START;
      line_o        <= 1'b0;
      shift_empty_o <= 1'b0;
      sub_cnt       <= '0;
      bit_cnt       <= '0;
      shreg         <= hold_word;
      hs_r          <= hi_speed;
      nine_r        <= nine_mode;
    end else if (state != TX_IDLE && tick) begin
      if (!bit_end) begin
        sub_cnt <= sub_cnt + 1'b1;
      end else begin
        sub_cnt <= '0;
        case (state)
          TX_START: begin
            line_o  <= shreg[0];
            shreg   <= shreg >> 1;
            bit_cnt <= '0;
            state   <= TX_DATA;
          end
          TX_DATA: begin
            if (bit_cnt == last_idx) begin
              line_o <= 1'b1;
              state  <= TX_STOP;
            end else begin
              line_o  <= shreg[0];
              shreg   <= shreg >> 1;
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          TX_STOP: begin
            line_o        <= 1'b1;
            shift_empty_o <= 1'b1;
            state         <= TX_IDLE;
          end
          default: state <= TX_IDLE;
        endcase
      end
    end
  end

  // R1: idle line is high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    shift_empty_o |-> line_o);

  // R5: a handoff starts the start bit on the next cycle
  p_load_start_r5: assert property (@(posedge clk) disable iff (rst)
    take |=> (!line_o && !shift_empty_o));

  // R11: losing the enable aborts the frame
  p_abort_r11: assert property (@(posedge clk) disable iff (rst)
    !run |=> (line_o && shift_empty_o));

endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              sync_mode,
  input  logic              nine_bit_mode,
  input  logic              hi_speed,
  input  logic              div_wide,
  input  logic [DIV_W-1:0]  div_value,
  input  logic              irq_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  output logic              serial_out,
  output logic              buf_empty,
  output logic              irq,
  output logic              shift_empty
);

  logic            active;
  logic            tick;
  logic            take;
  logic            hold_full;
  logic [DATA_W:0] hold_word;

  assign active = port_en && tx_en && !sync_mode;

  txb_baud_gen #(.DIV_W(DIV_W), .NARROW_W(NARROW_W)) u_baud (
    .clk       (clk),
    .rst       (rst),
    .run       (active),
    .restart   (take),
    .div_wide  (div_wide),
    .div_value (div_value),
    .tick      (tick)
  );

  txb_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .run       (active),
    .wr        (wr_valid),
    .wr_data   (wr_data),
    .wr_bit9   (wr_bit9),
    .take      (take),
    .irq_en    (irq_en),
    .hold_full (hold_full),
    .hold_word (hold_word),
    .buf_empty (buf_empty),
    .irq       (irq)
  );

  txb_shift_eng #(.DATA_W(DATA_W)) u_shift (
    .clk           (clk),
    .rst           (rst),
    .run           (active),
    .tick          (tick),
    .hi_speed      (hi_speed),
    .nine_mode     (nine_bit_mode),
    .hold_full     (hold_full),
    .hold_word     (hold_word),
    .take          (take),
    .line_o        (serial_out),
    .shift_empty_o (shift_empty)
  );

  // R10: a strobe while disabled never starts a frame
  p_ignore_wr_r10: assert property (@(posedge clk) disable iff (rst)
    (!active && wr_valid) |=> shift_empty);

endmodule

// File: tb/uart_dbuf_tx_bench.sv
module uart_dbuf_tx_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        port_en = 1'b0, tx_en = 1'b0, sync_mode = 1'b0;
  logic        nine_bit_mode = 1'b0, hi_speed = 1'b1, div_wide = 1'b0;
  logic [15:0] div_value = 16'h0000;
  logic        irq_en = 1'b0, wr_valid = 1'b0, wr_bit9 = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        serial_out, buf_empty, irq, shift_empty;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_dbuf_tx u_uart_dbuf_tx (
    .clk(clk), .rst(rst), .port_en(port_en), .tx_en(tx_en),
    .sync_mode(sync_mode), .nine_bit_mode(nine_bit_mode),
    .hi_speed(hi_speed), .div_wide(div_wide), .div_value(div_value),
    .irq_en(irq_en), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_bit9(wr_bit9), .serial_out(serial_out), .buf_empty(buf_empty),
    .irq(irq), .shift_empty(shift_empty)
  );

  // {data, bit9, nine, hi_speed, wide, divisor}
  localparam logic [27:0] VEC [0:5] = '{
    {8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000},
    {8'h3C, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0300},
    {8'hC3, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0001},
    {8'h81, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
    {8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0002},
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000}
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic b9, input logic nine,
                            input int bt, input logic ie);
    int c;
    int nb;
    logic e;
    nb = nine ? 9 : 8;
    c = cyc;
    wr_valid = 1'b1; wr_data = d; wr_bit9 = b9;
    wait_cyc(c + 1);
    wr_valid = 1'b0;
    chk(buf_empty, 1'b1, "R6 stale flag cycle after write");
    chk(shift_empty, 1'b1, "R9 still empty before start");
    wait_cyc(c + 2);
    chk(serial_out, 1'b0, "R5 start two cycles after write");
    chk(buf_empty, 1'b0, "R6 flag low at c+2");
    chk(shift_empty, 1'b0, "R9 busy in start bit");
    wait_cyc(c + 3);
    chk(buf_empty, 1'b1, "R6 flag back after handoff");
    chk(irq, ie, "R8 irq gating");
    wait_cyc(c + 2 + bt/2);
    chk(serial_out, 1'b0, "R1 start bit");
    wait_cyc(c + 1 + bt);
    chk(serial_out, 1'b0, "R3 last start cycle");
    wait_cyc(c + 2 + bt);
    chk(serial_out, d[0], "R3 first data cycle");
    for (int k = 1; k <= nb; k++) begin
      wait_cyc(c + 2 + bt*k + bt/2);
      e = (k == 9) ? b9 : d[k-1];
      chk(serial_out, e, (k == 9) ? "R2 ninth bit" : "R1 data bit");
    end
    wait_cyc(c + 2 + bt*(nb+1) + bt/2);
    chk(serial_out, 1'b1, nine ? "R1 stop bit" : "R2 stop after bit 7");
    chk(shift_empty, 1'b0, "R9 busy in stop bit");
    wait_cyc(c + 1 + bt*(nb+2));
    chk(shift_empty, 1'b0, "R3 last stop cycle");
    wait_cyc(c + 2 + bt*(nb+2));
    chk(shift_empty, 1'b1, "R9 empty after stop");
    chk(serial_out, 1'b1, "R1 idle high");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c;
    int x;
    logic [27:0] v;
    int bt;
    repeat (3) @(negedge clk);
    chk(serial_out, 1'b1, "R12 reset line");
    chk(shift_empty, 1'b1, "R12 reset shift empty");
    chk(buf_empty, 1'b0, "R12 reset flag");
    chk(irq, 1'b0, "R12 reset irq");
    rst = 1'b0;
    @(negedge clk);
    chk(buf_empty, 1'b0, "R7 flag low while disabled");
    port_en = 1'b1; tx_en = 1'b1;
    @(negedge clk);
    chk(buf_empty, 1'b1, "R7 flag forced on enable");
    chk(irq, 1'b0, "R8 irq masked");
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq, 1'b1, "R8 irq follows flag");

    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      nine_bit_mode = v[18]; hi_speed = v[17]; div_wide = v[16]; div_value = v[15:0];
      bt = (v[17] ? 16 : 64) * ((v[16] ? int'(v[15:0]) : int'(v[7:0])) + 1);
      repeat (2) @(negedge clk);
      send_frame(v[27:20], v[19], v[18], bt, irq_en);
      irq_en = (i % 2 == 0) ? 1'b0 : 1'b1;
    end

    // R4: back-to-back frames
    nine_bit_mode = 1'b0; hi_speed = 1'b1; div_wide = 1'b0; div_value = 16'h0000;
    repeat (2) @(negedge clk);
    c = cyc;
    wr_valid = 1'b1; wr_data = 8'h55; wr_bit9 = 1'b0;
    wait_cyc(c + 1); wr_valid = 1'b0;
    wait_cyc(c + 3);
    wr_valid = 1'b1; wr_data = 8'h0F;
    wait_cyc(c + 4); wr_valid = 1'b0;
    wait_cyc(c + 5);
    chk(buf_empty, 1'b0, "R4 second char waiting");
    x = c + 2 + 16*10;
    wait_cyc(x - 1);
    chk(serial_out, 1'b1, "R4 first stop bit");
    chk(buf_empty, 1'b0, "R4 flag low until handoff");
    wait_cyc(x);
    chk(serial_out, 1'b0, "R4 start directly after stop");
    chk(shift_empty, 1'b0, "R4 no idle gap");
    wait_cyc(x + 1);
    chk(buf_empty, 1'b1, "R4 flag after handoff");
    wait_cyc(x + 24);
    chk(serial_out, 1'b1, "R4 second char bit0");
    wait_cyc(x + 8 + 16*5);
    chk(serial_out, 1'b0, "R4 second char bit4");
    wait_cyc(x + 16*10 + 2);
    chk(shift_empty, 1'b1, "R4 done");

    // R11: abort mid frame
    c = cyc;
    wr_valid = 1'b1; wr_data = 8'h00;
    wait_cyc(c + 1); wr_valid = 1'b0;
    wait_cyc(c + 2 + 16*2 + 8);
    chk(serial_out, 1'b0, "R11 frame running");
    tx_en = 1'b0;
    @(negedge clk);
    chk(serial_out, 1'b1, "R11 line high after abort");
    chk(shift_empty, 1'b1, "R11 shift empty after abort");
    chk(buf_empty, 1'b0, "R7 flag low when disabled");
    repeat (40) @(negedge clk);
    chk(serial_out, 1'b1, "R11 frame not resumed");
    tx_en = 1'b1;
    @(negedge clk);
    chk(buf_empty, 1'b1, "R7 forced set on re-enable");
    repeat (40) @(negedge clk);
    chk(shift_empty, 1'b1, "R11 holding register emptied");

    // R10: writes ignored while not enabled
    sync_mode = 1'b1;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(serial_out, 1'b1, "R10 sync mode blocks write");
    chk(buf_empty, 1'b0, "R10 flag low in sync mode");
    sync_mode = 1'b0;
    @(negedge clk);
    chk(buf_empty, 1'b1, "R7 flag set when enable returns");
    repeat (20) @(negedge clk);
    chk(shift_empty, 1'b1, "R10 discarded write never sent");
    port_en = 1'b0;
    @(negedge clk);
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    port_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(serial_out, 1'b1, "R10 port disabled write ignored");
    chk(buf_empty, 1'b1, "R10 flag still empty");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule